// File: doc/BRIEF.md
# Hierarchical Status Register Array

The block gathers event reporting for an instrument into a two-level summary tree of the kind used by IEEE-488.2 style devices. Four groups collect occurrences: standard events, communication errors, analog-to-digital monitor events and instrument status. Each group keeps a sticky event register and an enable mask, and produces one summary bit. The group summaries, an idle flag and a master summary make up a status byte. A separate enable register for the status byte selects which bits drive the master summary.

Event pulses arrive on dedicated inputs. The instrument group instead watches live condition bits and latches their rising edges. A host reads and writes through a flat register port. Read data is combinational on the address. A read strobe on an event address empties that register at the next clock edge. The block sits behind a command parser. Serial transport and bus service-request signalling live outside it.

Top module: `status_hier_top`

## Requirements
- R1: After reset every event register, every enable register and the stored condition history are zero. The status byte then shows only the live idle bit (bit 4).
- R2: The enable registers are read/write on all 8 bits at these addresses: 1 status-byte enable, 3 standard, 5 communication, 7 analog-to-digital, 10 instrument. A write to any other address changes no register.
- R3: An event bit becomes 1 at the clock edge after its input pulse and stays 1 until its register is read. A read is `rd_i` high with the event address: 2 standard, 4 communication, 6 analog-to-digital, 9 instrument. The read returns the current contents in the same cycle, and the register is zero after that edge.
- R4: An event that arrives in the same cycle as a clearing read of its register is 1 after that edge.
- R5: Reading address 8 returns the live instrument condition bits, zero-extended. Reading it, the status byte (address 0) or an enable register changes no register.
- R6: An instrument event bit is set only when the matching condition bit is 1 in a cycle after being 0 in the previous cycle. A condition held at 1, or a falling edge, sets nothing.
- R7: A group summary is 1 when any bit is 1 in both its event and enable registers. The status byte has these bits: 7 communication, 6 master, 5 standard, 4 idle, 3 and 2 zero, 1 analog-to-digital, 0 instrument.
- R8: The master summary (`mss_o` and status-byte bit 6) is the OR over bits 7, 5, 4, 3, 2, 1 and 0 of the status byte ANDed with the status-byte enable register. Enable bit 6 has no effect.
- R9: Only bits 3..0 of the analog-to-digital event register and bits 4..0 of the instrument event register can become 1. The upper bits read as 0.
- R10: Addresses 11 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Read strobe; clears the addressed event register |
| wr_i | input | 1 | Write strobe for enable registers |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| std_evt_i | input | 8 | Standard event pulses |
| com_evt_i | input | 8 | Communication error pulses |
| adc_evt_i | input | 4 | Analog-to-digital monitor pulses |
| ins_cond_i | input | 5 | Live instrument condition bits |
| idle_i | input | 1 | Live idle flag |
| stb_o | output | 8 | Status byte |
| mss_o | output | 1 | Master summary |

## Verification
The assertions assume that the event inputs are one-cycle pulses that may coincide with any read. They also assume that `rd_i` and `wr_i` may be high together, because a write only reaches enable addresses and a clear only reaches event addresses. The assertions check the sticky hold, the clear after a read and the survival of a coincident event only when the strobes and pulses are well defined after reset. The stimulus drives inputs only between clock edges, holds every input at a known value, and fills the random phase with sparse event pulses. Random reads and writes cover the full address range, unmapped addresses included.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int DW = 8;
  localparam int AW = 4;

  typedef enum logic [AW-1:0] {
    A_STB    = 4'd0,
    A_SRE    = 4'd1,
    A_STD_EV = 4'd2,
    A_STD_EN = 4'd3,
    A_COM_EV = 4'd4,
    A_COM_EN = 4'd5,
    A_ADC_EV = 4'd6,
    A_ADC_EN = 4'd7,
    A_INS_CR = 4'd8,
    A_INS_EV = 4'd9,
    A_INS_EN = 4'd10
  } addr_e;

  // status byte bit positions
  localparam int SB_INS  = 0;
  localparam int SB_ADC  = 1;
  localparam int SB_IDLE = 4;
  localparam int SB_STD  = 5;
  localparam int SB_MSS  = 6;
  localparam int SB_COM  = 7;
endpackage

// File: rtl/evt_group.sv
module evt_group #(
  parameter int          DW        = 8,
  parameter logic [DW-1:0] DEF_MASK = '1,
  parameter bit          EDGE_MODE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] src_i,
  input  logic          clr_i,
  input  logic          en_we_i,
  input  logic [DW-1:0] en_wdata_i,
  output logic [DW-1:0] evt_o,
  output logic [DW-1:0] en_o,
  output logic          sum_o
);
  logic [DW-1:0] evt_q, en_q, hit;

  generate
    if (EDGE_MODE) begin : g_edge
      logic [DW-1:0] cond_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cond_q <= '0;
        else         cond_q <= src_i;
      end
      assign hit = src_i & ~cond_q;
    end else begin : g_pulse
      assign hit = src_i;
    end
  endgenerate

  // a coincident event survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= (clr_i ? '0 : evt_q) | (hit & DEF_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign evt_o = evt_q;
  assign en_o  = en_q;
  assign sum_o = |(evt_q & en_q);
endmodule

// File: rtl/stb_unit.sv
module stb_unit
  import status_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          com_sum_i,
  input  logic          std_sum_i,
  input  logic          adc_sum_i,
  input  logic          ins_sum_i,
  input  logic          idle_i,
  input  logic          sre_we_i,
  input  logic [DW-1:0] sre_wdata_i,
  output logic [DW-1:0] sre_o,
  output logic [DW-1:0] stb_o,
  output logic          mss_o
);
  localparam logic [DW-1:0] MSS_EXCL = ~(DW'(1) << SB_MSS);

  logic [DW-1:0] sre_q, base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sre_q <= '0;
    else if (sre_we_i) sre_q <= sre_wdata_i;
  end

  always_comb begin
    base          = '0;
    base[SB_COM]  = com_sum_i;
    base[SB_STD]  = std_sum_i;
    base[SB_IDLE] = idle_i;
    base[SB_ADC]  = adc_sum_i;
    base[SB_INS]  = ins_sum_i;
  end

  assign mss_o = |(base & sre_q & MSS_EXCL);

  always_comb begin
    stb_o         = base;
    stb_o[SB_MSS] = mss_o;
  end

  assign sre_o = sre_q;
endmodule

// File: rtl/status_hier_top.sv
module status_hier_top
  import status_pkg::*;
#(
  parameter int ADC_BITS = 4,
  parameter int INS_BITS = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  input  logic [DW-1:0]       std_evt_i,
  input  logic [DW-1:0]       com_evt_i,
  input  logic [ADC_BITS-1:0] adc_evt_i,
  input  logic [INS_BITS-1:0] ins_cond_i,
  input  logic                idle_i,
  output logic [DW-1:0]       stb_o,
  output logic                mss_o
);
  localparam logic [DW-1:0] ADC_DEF = DW'((1 << ADC_BITS) - 1);
  localparam logic [DW-1:0] INS_DEF = DW'((1 << INS_BITS) - 1);

  logic [DW-1:0] std_ev, std_en, com_ev, com_en, adc_ev, adc_en, ins_ev, ins_en, sre;
  logic [DW-1:0] adc_src, ins_src;
  logic          std_sum, com_sum, adc_sum, ins_sum;

  assign adc_src = DW'(adc_evt_i);
  assign ins_src = DW'(ins_cond_i);

  function automatic logic hit(input logic s, input logic [AW-1:0] a, input addr_e r);
    return s && (a == r);
  endfunction

  evt_group #(.DW(DW), .DEF_MASK('1), .EDGE_MODE(1'b0)) u_std (
    .clk_i, .rst_ni, .src_i(std_evt_i),
    .clr_i(hit(rd_i, addr_i, A_STD_EV)),
    .en_we_i(hit(wr_i, addr_i, A_STD_EN)), .en_wdata_i(wdata_i),
    .evt_o(std_ev), .en_o(std_en), .sum_o(std_sum));

  evt_group #(.DW(DW), .DEF_MASK('1), .EDGE_MODE(1'b0)) u_com (
    .clk_i, .rst_ni, .src_i(com_evt_i),
    .clr_i(hit(rd_i, addr_i, A_COM_EV)),
    .en_we_i(hit(wr_i, addr_i, A_COM_EN)), .en_wdata_i(wdata_i),
    .evt_o(com_ev), .en_o(com_en), .sum_o(com_sum));

  evt_group #(.DW(DW), .DEF_MASK(ADC_DEF), .EDGE_MODE(1'b0)) u_adc (
    .clk_i, .rst_ni, .src_i(adc_src),
    .clr_i(hit(rd_i, addr_i, A_ADC_EV)),
    .en_we_i(hit(wr_i, addr_i, A_ADC_EN)), .en_wdata_i(wdata_i),
    .evt_o(adc_ev), .en_o(adc_en), .sum_o(adc_sum));

  evt_group #(.DW(DW), .DEF_MASK(INS_DEF), .EDGE_MODE(1'b1)) u_ins (
    .clk_i, .rst_ni, .src_i(ins_src),
    .clr_i(hit(rd_i, addr_i, A_INS_EV)),
    .en_we_i(hit(wr_i, addr_i, A_INS_EN)), .en_wdata_i(wdata_i),
    .evt_o(ins_ev), .en_o(ins_en), .sum_o(ins_sum));

  stb_unit u_stb (
    .clk_i, .rst_ni,
    .com_sum_i(com_sum), .std_sum_i(std_sum), .adc_sum_i(adc_sum), .ins_sum_i(ins_sum),
    .idle_i, .sre_we_i(hit(wr_i, addr_i, A_SRE)), .sre_wdata_i(wdata_i),
    .sre_o(sre), .stb_o(stb_o), .mss_o(mss_o));

  always_comb begin
    unique case (addr_i)
      A_STB:    rdata_o = stb_o;
      A_SRE:    rdata_o = sre;
      A_STD_EV: rdata_o = std_ev;
      A_STD_EN: rdata_o = std_en;
      A_COM_EV: rdata_o = com_ev;
      A_COM_EN: rdata_o = com_en;
      A_ADC_EV: rdata_o = adc_ev;
      A_ADC_EN: rdata_o = adc_en;
      A_INS_CR: rdata_o = ins_src;
      A_INS_EV: rdata_o = ins_ev;
      A_INS_EN: rdata_o = ins_en;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/status_hier_chk.sv
module status_hier_chk
  import status_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] std_evt_i,
  input logic [DW-1:0] std_ev,
  input logic [DW-1:0] std_en,
  input logic [DW-1:0] adc_ev,
  input logic [DW-1:0] ins_ev,
  input logic [DW-1:0] sre,
  input logic [DW-1:0] stb_o,
  input logic          mss_o
);
  p_en_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_STD_EN) |=> (std_en == $past(wdata_i)));

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i == A_STD_EV) |=> ((std_ev & $past(std_ev)) == $past(std_ev)));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_STD_EV && std_evt_i == '0) |=> (std_ev == '0));

  p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_STD_EV) |=> ((std_ev & $past(std_evt_i)) == $past(std_evt_i)));

  p_mss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mss_o == |(stb_o & sre & 8'hBF));

  p_undef_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_ev[7:4] == 4'h0) && (ins_ev[7:5] == 3'h0));
endmodule

bind status_hier_top status_hier_chk u_chk (
  .clk_i, .rst_ni, .rd_i, .wr_i, .addr_i, .wdata_i, .std_evt_i,
  .std_ev, .std_en, .adc_ev, .ins_ev, .sre, .stb_o, .mss_o);

// File: tb/status_hier_top_bench.sv
`timescale 1ns/1ps
module status_hier_top_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rd = 1'b0, wr = 1'b0, idle = 1'b1;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0, std_evt = 8'd0, com_evt = 8'd0;
  logic [3:0] adc_evt = 4'd0;
  logic [4:0] cond = 5'd0;
  logic [7:0] rdata, stb;
  logic       mss;

  int vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  status_hier_top u_status_hier_top (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .std_evt_i(std_evt), .com_evt_i(com_evt), .adc_evt_i(adc_evt),
    .ins_cond_i(cond), .idle_i(idle), .stb_o(stb), .mss_o(mss));

  // behavioural reference
  int m_std, m_com, m_adc, m_ins, m_prev;
  int e_std, e_com, e_adc, e_ins, e_sre;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_std = 0; m_com = 0; m_adc = 0; m_ins = 0; m_prev = 0;
      e_std = 0; e_com = 0; e_adc = 0; e_ins = 0; e_sre = 0;
    end else begin
      if (rd && addr == 2) m_std = 0;
      if (rd && addr == 4) m_com = 0;
      if (rd && addr == 6) m_adc = 0;
      if (rd && addr == 9) m_ins = 0;
      m_std = m_std | std_evt;
      m_com = m_com | com_evt;
      m_adc = m_adc | adc_evt;
      m_ins = m_ins | (cond & ~m_prev & 'h1f);
      m_prev = cond;
      if (wr) begin
        if (addr == 1)  e_sre = wdata;
        if (addr == 3)  e_std = wdata;
        if (addr == 5)  e_com = wdata;
        if (addr == 7)  e_adc = wdata;
        if (addr == 10) e_ins = wdata;
      end
    end
  end

  function automatic int exp_stb();
    int b = 0, ms;
    if ((m_com & e_com) != 0) b += 128;
    if ((m_std & e_std) != 0) b += 32;
    if (idle)                 b += 16;
    if ((m_adc & e_adc) != 0) b += 2;
    if ((m_ins & e_ins) != 0) b += 1;
    ms = ((b & e_sre & 'hbf) != 0);
    return b + 64 * ms;
  endfunction

  function automatic int exp_rd();
    case (addr)
      0: return exp_stb();   1: return e_sre;
      2: return m_std;       3: return e_std;
      4: return m_com;       5: return e_com;
      6: return m_adc;       7: return e_adc;
      8: return cond;        9: return m_ins;
      10: return e_ins;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag();
    case (addr)
      0: return "R7";
      2, 4, 6, 9: return "R3";
      8: return "R5";
      1, 3, 5, 7, 10: return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(int'(stb), exp_stb(), "R7 stb");
    chk(int'(mss), (exp_stb() >> 6) & 1, "R8 mss");
    chk(int'(rdata), exp_rd(), rd_tag());
  end

  task automatic cyc(input bit r, input bit w, input int a, input int d);
    rd = r; wr = w; addr = 4'(a); wdata = 8'(d);
    @(posedge clk); #1;
    rd = 1'b0; wr = 1'b0; std_evt = 8'h0; com_evt = 8'h0; adc_evt = 4'h0;
  endtask

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 chk(int'(stb), 'h10, "R1 reset stb");
    chk(int'(rdata), 'h10, "R1 reset rdata");
    cyc(0, 0, 3, 0); #1 chk(int'(rdata), 0, "R1 std enable cleared");
    // R2 enable writes and ignored writes
    cyc(0, 1, 3, 'hA5); #1 chk(int'(rdata), 'hA5, "R2 std enable");
    cyc(0, 1, 2, 'hFF); #1 chk(int'(rdata), 0, "R2 write to event ignored");
    cyc(0, 1, 8, 'hFF); #1 chk(int'(rdata), 0, "R2 write to condition ignored");
    cyc(0, 1, 5, 'hFF); cyc(0, 1, 7, 'hFF); cyc(0, 1, 10, 'hFF);
    cyc(0, 1, 1, 'hBF);
    // R3 sticky then clear
    std_evt = 8'h81; cyc(0, 0, 2, 0);
    #1 chk(int'(rdata), 'h81, "R3 event latched");
    chk(int'(stb[5]), 1, "R7 std summary");
    cyc(0, 0, 2, 0); #1 chk(int'(rdata), 'h81, "R3 event held");
    cyc(1, 0, 2, 0); #1 chk(int'(rdata), 0, "R3 cleared by read");
    // R4 coincident event
    std_evt = 8'h04; cyc(0, 0, 2, 0);
    std_evt = 8'h10; cyc(1, 0, 2, 0);
    #1 chk(int'(rdata), 'h10, "R4 coincident event kept");
    // R6 edge detection and R5 condition read
    cond = 5'h03; cyc(0, 0, 9, 0); #1 chk(int'(rdata), 'h03, "R6 rising edges");
    cyc(1, 0, 9, 0); cyc(0, 0, 9, 0); #1 chk(int'(rdata), 0, "R6 held high no event");
    cond = 5'h01; cyc(0, 0, 9, 0); #1 chk(int'(rdata), 0, "R6 falling no event");
    cyc(1, 0, 8, 0); #1 chk(int'(rdata), 'h01, "R5 live condition");
    cyc(1, 0, 0, 0); cyc(1, 0, 1, 0); #1 chk(int'(rdata), 'hBF, "R5 enable read no effect");
    // R9 undefined bits
    adc_evt = 4'hF; cyc(0, 0, 6, 0); #1 chk(int'(rdata), 'h0F, "R9 adc defined bits");
    cond = 5'h1F; cyc(0, 0, 9, 0); #1 chk(int'(rdata), 'h1E, "R9 ins defined bits");
    // R8 enable bit 6 alone does nothing
    cyc(0, 1, 1, 'h40); #1 chk(int'(mss), 0, "R8 enable bit 6 ignored");
    cyc(0, 1, 1, 'h10); #1 chk(int'(mss), 1, "R8 idle selected");
    // R10 unmapped
    for (int a = 11; a < 16; a++) begin
      cyc(1, 1, a, 'hFF); #1 chk(int'(rdata), 0, "R10 unmapped");
    end
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      std_evt = 8'($urandom & $urandom & $urandom);
      com_evt = 8'($urandom & $urandom & $urandom);
      adc_evt = 4'($urandom & $urandom);
      if ($urandom % 4 == 0) cond = 5'($urandom);
      idle = 1'($urandom);
      cyc(($urandom % 3) == 0, ($urandom % 4) == 0, int'($urandom % 16), int'($urandom % 256));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule